// File: doc/BRIEF.md
# Self-Timed Bulk Erase Controller for a Byte-Wide Flash Array

This block sits on the device side of a byte-wide flash array. The array has a parameterised address width: 15 address bits give the full 32768 x 8 organisation, and a smaller default keeps elaboration light. A host bus with active-low chip-enable, output-enable and write-enable strobes reads array bytes directly and writes bytes into a command register. All strobes are sampled on the block clock. A write is taken on the clock where write-enable is seen rising while chip-enable is low.

Erasing the whole array takes the byte 30h written twice in a row. The first write only arms the block. The second write, accepted only while the programming-voltage-present input is high, launches a sequence that needs no further help from the host. The sequence writes 00h to every location and reads each one back. It then waits a self-timed erase interval, writes FFh to every location and reads each one back again. While this runs, any enabled read returns a status byte whose top bit is 0. When the sequence ends, reads return array data again, so the top bit reads 1.

Each address step takes one clock. A full operation therefore lasts four array sweeps plus the erase interval, and the length of the interval is a parameter.

Top module: `flash_erase_ctrl`

## Requirements
- R1: The array holds 2**ADDR_W bytes of 8 bits, and `addr` selects one of them. ADDR_W = 15 gives 32768 locations.
- R2: A single accepted write of 30h arms the controller and starts no array activity. Enabled reads keep returning array contents.
- R3: An accepted write of 30h, directly following the arming write while `vpp_ok` is 1, starts the erase at the clock where the rising write-enable is sampled.
- R4: The operation writes and verifies 00h at every location, then waits ERASE_CYC clocks, then writes and verifies FFh at every location. Each step takes one clock, so the block is busy for exactly 4*2**ADDR_W + ERASE_CYC clocks after the start clock.
- R5: When the operation ends, every location reads FFh and the controller is back in read mode.
- R6: While the operation runs, a read with chip-enable and output-enable low returns the status byte 00h, whose bit 7 is 0.
- R7: Any byte other than 30h written after the arming write cancels the arming. A later single 30h only arms again.
- R8: A second 30h written while `vpp_ok` is 0 starts nothing and clears the arming.
- R9: Writes during the operation are ignored. They do not change its length and leave the controller unarmed when it ends.
- R10: `dq_oe` is 1 only when `ce_n` and `oe_n` are both 0. While `dq_oe` is 0, `dq_out` is 00h.
- R11: A write-enable rising edge with `ce_n` high is not a write. It neither arms, disarms nor starts anything.
- R12: Reset leaves the controller idle, in read mode and unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vpp_ok | input | 1 | Programming voltage present; gates the erase start |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable; its rising edge takes a write |
| addr | input | ADDR_W | Byte address for reads |
| dq_in | input | 8 | Byte written to the command register |
| dq_out | output | 8 | Read data or status byte, 00h when not driven |
| dq_oe | output | 1 | High when `dq_out` is driven; low means high impedance |

## Verification
The bench counts, read by read, how long bit 7 stays low after a start. A design that skipped the zero pre-programming pass, shortened a sweep or miscounted the erase interval would give the wrong count. The bench also goes after the arming rules: a foreign byte between two 30h writes, a second 30h without programming voltage, a rising write-enable with chip-enable high, a reset between the two writes, and a lone 30h after an operation that was hit with writes while busy. A decoder that kept stale arming, or that started from any of these, would drop into status mode where the bench expects FFh. Output-enable gating is checked with each strobe held high in turn.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] CMD_BULK_ERASE = 8'h30;
  localparam logic [7:0] CELL_ZERO      = 8'h00;
  localparam logic [7:0] CELL_ONES      = 8'hFF;
  localparam logic [7:0] STATUS_BUSY    = 8'h00;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PROG,
    SQ_PVFY,
    SQ_HOLD,
    SQ_WIPE,
    SQ_EVFY
  } seq_state_e;

  // clocks spent busy for one full erase operation
  function automatic int unsigned op_cycles(input int unsigned depth,
                                            input int unsigned hold);
    return 4 * depth + hold;
  endfunction

endpackage

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic [7:0] din,
  input  logic       vpp_ok,
  input  logic       busy,
  output logic       wr_evt,
  output logic       armed,
  output logic       start
);

  logic we_n_q;
  logic armed_q;
  logic is_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) we_n_q <= 1'b1;
    else        we_n_q <= we_n;
  end

  assign wr_evt = !ce_n && we_n && !we_n_q;
  assign is_cmd = (din == CMD_BULK_ERASE);
  assign start  = wr_evt && armed_q && is_cmd && vpp_ok && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr_evt) begin
      armed_q <= !busy && !armed_q && is_cmd;
    end
  end

  assign armed = armed_q;

  // R2
  arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(!ce_n && we_n && !we_n_q && din == CMD_BULK_ERASE));

  // R9
  busy_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !armed_q);

endmodule

// File: rtl/fe_seq.sv
module fe_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int ERASE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              vpp_ok,
  input  logic [7:0]        vfy_data,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(ERASE_CYC + 1);
  localparam int unsigned TOTAL = op_cycles(DEPTH, ERASE_CYC);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] cnt_q;
  logic [TW-1:0]     tmr_q;
  logic              last;
  logic              hold_done;
  logic [31:0]       run_q;

  assign last      = &cnt_q;
  assign hold_done = (tmr_q == TW'(ERASE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_PROG;
          cnt_q   <= '0;
        end
        SQ_PROG: begin
          cnt_q <= cnt_q + ADDR_W'(1);
          if (last) state_q <= SQ_PVFY;
        end
        SQ_PVFY: begin
          if (vfy_data != CELL_ZERO) begin
            state_q <= SQ_PROG;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + ADDR_W'(1);
            if (last) begin
              state_q <= SQ_HOLD;
              tmr_q   <= '0;
            end
          end
        end
        SQ_HOLD: begin
          tmr_q <= tmr_q + TW'(1);
          if (hold_done) begin
            state_q <= SQ_WIPE;
            cnt_q   <= '0;
          end
        end
        SQ_WIPE: begin
          cnt_q <= cnt_q + ADDR_W'(1);
          if (last) state_q <= SQ_EVFY;
        end
        SQ_EVFY: begin
          if (vfy_data != CELL_ONES) begin
            state_q <= SQ_WIPE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + ADDR_W'(1);
            if (last) state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign mem_we    = (state_q == SQ_PROG) || (state_q == SQ_WIPE);
  assign mem_wdata = (state_q == SQ_WIPE) ? CELL_ONES : CELL_ZERO;
  assign mem_addr  = cnt_q;

  // busy-cycle counter, kept for the duration check below
  always_ff @(posedge clk) begin
    if (!rst_n)     run_q <= '0;
    else if (start) run_q <= '0;
    else if (busy)  run_q <= run_q + 32'd1;
  end

  // R8
  start_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> vpp_ok);

  // R3
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && !start) |=> state_q == SQ_IDLE);

  // R4
  pre_prog_vfy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SQ_PVFY |-> vfy_data == CELL_ZERO);

  // R4
  hold_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HOLD && $past(state_q) != SQ_HOLD) |-> $past(state_q) == SQ_PVFY);

  // R5
  erase_vfy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SQ_EVFY |-> vfy_data == CELL_ONES);

  // R4
  op_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == TOTAL);

endmodule

// File: rtl/fe_array.sv
module fe_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [7:0]        host_data,
  output logic [7:0]        vfy_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign host_data = cells[host_addr];
  assign vfy_data  = cells[waddr];

  // R4
  wr_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wdata == 8'h00 || wdata == 8'hFF));

endmodule

// File: rtl/fe_bus.sv
module fe_bus
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       busy,
  input  logic [7:0] arr_data,
  output logic [7:0] dq_out,
  output logic       dq_oe
);

  logic [7:0] sel;

  assign sel    = busy ? STATUS_BUSY : arr_data;
  assign dq_oe  = !ce_n && !oe_n;
  assign dq_out = dq_oe ? sel : 8'h00;

  // R6
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> !dq_out[7]);

  // R10
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (!dq_oe && dq_out == 8'h00));

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int ERASE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);

  logic              wr_evt;
  logic              armed;
  logic              start;
  logic              busy;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic [7:0]        host_data;
  logic [7:0]        vfy_data;

  fe_cmd_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .din    (dq_in),
    .vpp_ok (vpp_ok),
    .busy   (busy),
    .wr_evt (wr_evt),
    .armed  (armed),
    .start  (start)
  );

  fe_seq #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vpp_ok    (vpp_ok),
    .vfy_data  (vfy_data),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  fe_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (mem_we),
    .waddr     (mem_addr),
    .wdata     (mem_wdata),
    .host_addr (addr),
    .host_data (host_data),
    .vfy_data  (vfy_data)
  );

  fe_bus u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .busy     (busy),
    .arr_data (host_data),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  // R11
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !wr_evt);

  // R7
  foreign_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && dq_in != CMD_BULK_ERASE) |=> !armed);

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!busy && !armed));

endmodule

// File: tb/flash_erase_ctrl_tb_top.sv
module flash_erase_ctrl_tb_top;

  localparam int AW    = 6;
  localparam int HOLD  = 20;
  localparam int DEPTH = 1 << AW;
  localparam int T_OP  = DEPTH * 4 + HOLD;

  logic          clk   = 1'b0;
  logic          rst_n = 1'b0;
  logic          vpp   = 1'b1;
  logic          ce_n  = 1'b1;
  logic          oe_n  = 1'b1;
  logic          we_n  = 1'b1;
  logic [AW-1:0] addr  = '0;
  logic [7:0]    din   = 8'h00;
  logic [7:0]    dout;
  logic          doe;

  always #2 clk = ~clk;

  flash_erase_ctrl #(.ADDR_W(AW), .ERASE_CYC(HOLD)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .vpp_ok (vpp),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .addr   (addr),
    .dq_in  (din),
    .dq_out (dout),
    .dq_oe  (doe)
  );

  typedef struct {
    logic [7:0] exp;
    logic       exp_oe;
    string      req;
  } item_t;

  item_t q[$];
  item_t it;
  int    checks = 0;
  int    errors = 0;
  logic  smp = 1'b0;
  bit    finished = 1'b0;

  // monitor: pops one expected item per sample strobe
  initial forever begin
    @(posedge smp);
    it = q.pop_front();
    checks++;
    if (doe !== it.exp_oe || dout !== it.exp) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
               it.req, doe, dout, it.exp_oe, it.exp);
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  // driver: sets up a read, pushes the expected item, fires the monitor
  task automatic rd(input logic [AW-1:0] a, input logic c, input logic o,
                    input logic [7:0] e, input string r);
    item_t x;
    @(negedge clk);
    we_n = 1'b1;
    addr = a;
    ce_n = c;
    oe_n = o;
    #1;
    x.exp_oe = !c && !o;
    x.exp    = x.exp_oe ? e : 8'h00;
    x.req    = r;
    q.push_back(x);
    smp = 1'b1;
    #1 smp = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic c);
    @(negedge clk);
    oe_n = 1'b1;
    ce_n = c;
    din  = d;
    we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
  endtask

  // counts consecutive reads showing bit 7 low; also returns first byte
  task automatic poll(output int n, output logic [7:0] first);
    n = 0;
    first = 8'hxx;
    for (int i = 0; i < 2 * T_OP; i++) begin
      @(negedge clk);
      ce_n = 1'b0;
      oe_n = 1'b0;
      #1;
      if (i == 0) first = dout;
      if (doe && !dout[7]) n++;
      else break;
    end
  endtask

  initial begin
    int n;
    logic [7:0] f;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R10: chip enable high gives an undriven bus
    rd(0, 1'b1, 1'b0, 8'h00, "R10");

    // R3, R4, R6: full erase with programming voltage
    wr(8'h30, 1'b0);
    wr(8'h30, 1'b0);
    poll(n, f);
    chk(n == T_OP, "R4", n, T_OP);
    chk(f == 8'h00, "R6", int'(f), 0);

    // R5, R1: every location reads FFh
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), 1'b0, 1'b0, 8'hFF, "R5");

    // R2: single setup leaves read mode
    wr(8'h30, 1'b0);
    rd(5, 1'b0, 1'b0, 8'hFF, "R2");
    repeat (10) @(negedge clk);
    rd(DEPTH - 1, 1'b0, 1'b0, 8'hFF, "R2");
    wr(8'h00, 1'b0);

    // R7: foreign byte cancels the setup
    wr(8'h30, 1'b0);
    wr(8'h55, 1'b0);
    wr(8'h30, 1'b0);
    rd(7, 1'b0, 1'b0, 8'hFF, "R7");
    wr(8'h00, 1'b0);

    // R8: no programming voltage, second 30h ignored
    vpp = 1'b0;
    wr(8'h30, 1'b0);
    wr(8'h30, 1'b0);
    rd(3, 1'b0, 1'b0, 8'hFF, "R8");
    vpp = 1'b1;
    wr(8'h30, 1'b0);
    rd(3, 1'b0, 1'b0, 8'hFF, "R8");
    wr(8'h00, 1'b0);

    // R11: write strobe with chip enable high is not a write
    wr(8'h30, 1'b0);
    wr(8'h30, 1'b1);
    rd(9, 1'b0, 1'b0, 8'hFF, "R11");
    wr(8'h30, 1'b0);
    poll(n, f);
    chk(n == T_OP, "R11", n, T_OP);

    // R9: writes while busy change nothing
    wr(8'h30, 1'b0);
    wr(8'h30, 1'b0);
    wr(8'h30, 1'b0);
    wr(8'h30, 1'b0);
    poll(n, f);
    chk(n == T_OP - 4, "R9", n, T_OP - 4);
    wr(8'h30, 1'b0);
    rd(11, 1'b0, 1'b0, 8'hFF, "R9");
    wr(8'h00, 1'b0);

    // R12: reset between the two 30h writes clears the arming
    wr(8'h30, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr(8'h30, 1'b0);
    rd(13, 1'b0, 1'b0, 8'hFF, "R12");
    wr(8'h00, 1'b0);

    // R10: output enable high gives an undriven bus
    rd(2, 1'b0, 1'b1, 8'h00, "R10");
    rd(2, 1'b1, 1'b1, 8'h00, "R10");
    rd(2, 1'b0, 1'b0, 8'hFF, "R10");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule